// File: doc/BRIEF.md
# Zero-Suppressed Hit Packet Encoder

This block turns the zero-suppressed hits of one bunch crossing, coming from a 128-strip readout chip, into a variable-length packet on a one-bit serial output. A crossing descriptor comes first. It carries a 4-bit crossing ID, a flag saying that no hits follow, and a flag saying that the hit buffer overflowed. The hits of that crossing then follow one per handshake on a separate stream, and the last hit is marked. The block stores and counts the hits before the header leaves, so the packet type and the length field are fixed by the time the first bit is sent.

A short 6-bit header is used for crossings without hits. A normal packet adds a 6-bit hit count and one 12-bit word per hit. A truncated packet carries a quarter-scaled count and no hit words. When nothing is pending at a packet boundary, the block fills the line with a 6-bit idle pattern. A sync request is answered with a fixed 12-bit pattern. One crossing is held at a time. The next descriptor is taken only after the last bit of the current crossing's packet has left, so packets leave in the order their crossings were accepted.

Top module: `zsp_packet_enc`

## Requirements
- R1: While reset is applied, `ser_valid_o`, `hit_ready_o` and `sync_ack_o` are 0 and `evt_ready_o` is 1. After reset, the first packet on the serial line is idle, unless a crossing or a sync request is already pending.
- R2: One bit moves per cycle with `ser_valid_o` and `ser_ready_i` both high. Every field goes most significant bit first. While `ser_ready_i` is low, `ser_bit_o` holds its value. Once `ser_valid_o` rises after reset, it stays high.
- R3: A crossing accepted with `evt_nohit_i`=1 yields a 6-bit packet: the crossing ID, then 1, then 0. This flag takes precedence over `evt_full_i`.
- R4: A normal packet is 12 bits of header: crossing ID, 0, 0, then a 6-bit hit count. It is followed by one 12-bit word per hit, in arrival order, each word being the 7-bit channel followed by the 5-bit ADC value.
- R5: A crossing is truncated when its hit count is strictly greater than the threshold. A count equal to the threshold (up to 63) stays normal.
- R6: A truncated packet is crossing ID, 0, 1, then the hit count divided by 4 in 6 bits, with no hit words. It is also produced when `evt_full_i` was set at acceptance. The count saturates at 255.
- R7: `thr_i` is sampled when the descriptor is accepted. Changes to it while that crossing's hits arrive do not alter its packet.
- R8: At a packet boundary with nothing pending, the 6-bit idle pattern 000011 is sent. No packet is ever interrupted.
- R9: There is one packet per accepted crossing, in acceptance order, and none is dropped. `evt_ready_o` is low from the cycle after acceptance until the last bit of that crossing's packet has left.
- R10: A pending `sync_req_i` at a packet boundary sends the 12-bit pattern `SYNC_PAT` (default 101011110000) ahead of any pending crossing. `sync_ack_o` is a one-cycle pulse in the cycle the pattern's first bit is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_i | input | 6 | Truncation threshold (63 by default use) |
| evt_valid_i | input | 1 | Crossing descriptor valid |
| evt_ready_o | output | 1 | Descriptor accepted when high with valid |
| evt_bx_i | input | 4 | Crossing ID |
| evt_nohit_i | input | 1 | No hits follow (veto, header-only or empty) |
| evt_full_i | input | 1 | Hit buffer overflowed for this crossing |
| hit_valid_i | input | 1 | Hit valid |
| hit_ready_o | output | 1 | Hit accepted when high with valid |
| hit_chan_i | input | 7 | Hit channel |
| hit_adc_i | input | 5 | Hit ADC value |
| hit_last_i | input | 1 | Marks the last hit of the crossing |
| sync_req_i | input | 1 | Sync packet request, held until acknowledged |
| sync_ack_o | output | 1 | Sync packet started |
| ser_valid_o | output | 1 | Serial bit valid |
| ser_ready_i | input | 1 | Serial sink ready |
| ser_bit_o | output | 1 | Serial data, MSB first |

## Verification
The reset synchronizer adds two cycles after release, so the first idle bit appears in the third cycle. `evt_ready_o` falls one cycle after a descriptor handshake. `sync_ack_o` rises in the same cycle the first sync bit is driven. Each packet starts on the clock edge that moves the last bit of the one before it. Inputs are driven one nanosecond after a rising edge, and every transferred bit is taken from the falling edge into a queue. Packet contents are therefore checked by their position in the bit stream and not by absolute cycle counts, and this holds under random back-pressure as well. The single-cycle results (ready drop, acknowledge pulse, held bit during a stall) are sampled in the cycle that follows the driving edge.

// File: rtl/zsp_pkg.sv
package zsp_pkg;
  localparam int BX_W   = 4;
  localparam int CH_W   = 7;
  localparam int ADC_W  = 5;
  localparam int LEN_W  = 6;
  localparam int CNT_W  = LEN_W + 2;
  localparam int HIT_W  = CH_W + ADC_W;
  localparam int HDR_W  = BX_W + 2;
  localparam int WORD_W = HDR_W + LEN_W;
  localparam int BITS_W = $clog2(WORD_W + 1);
  localparam int DEPTH  = 2 ** LEN_W;
  localparam int MAXH   = DEPTH - 1;

  typedef enum logic [1:0] {K_EMPTY, K_NORMAL, K_TRUNC} kind_t;

  typedef struct packed {
    logic [BX_W-1:0]  bx;
    kind_t            kind;
    logic [LEN_W-1:0] len;
  } desc_t;
endpackage

// File: rtl/zsp_hitmem.sv
module zsp_hitmem #(
  parameter int DEPTH = 64,
  parameter int W     = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/zsp_collect.sv
module zsp_collect
  import zsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] thr_i,
  input  logic             evt_valid_i,
  output logic             evt_ready_o,
  input  logic [BX_W-1:0]  evt_bx_i,
  input  logic             evt_nohit_i,
  input  logic             evt_full_i,
  input  logic             hit_valid_i,
  output logic             hit_ready_o,
  input  logic [HIT_W-1:0] hit_word_i,
  input  logic             hit_last_i,
  output logic             wr_en_o,
  output logic [LEN_W-1:0] wr_addr_o,
  output logic [HIT_W-1:0] wr_data_o,
  output logic             desc_valid_o,
  output desc_t            desc_o,
  input  logic             take_i,
  input  logic             end_i
);
  typedef enum logic [1:0] {C_WAIT, C_HITS, C_READY, C_SEND} cst_t;

  cst_t             st_q, st_d;
  logic [BX_W-1:0]  bx_q;
  logic             full_q, nohit_q;
  logic [LEN_W-1:0] thr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ld_en, hit_fire, cnt_en;
  logic             is_trunc;

  assign evt_ready_o = (st_q == C_WAIT);
  assign hit_ready_o = (st_q == C_HITS);
  assign ld_en       = evt_ready_o && evt_valid_i;
  assign hit_fire    = hit_ready_o && hit_valid_i;
  assign cnt_en      = ld_en || hit_fire;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      C_WAIT: if (evt_valid_i) begin
        cnt_d = '0;
        st_d  = evt_nohit_i ? C_READY : C_HITS;
      end
      C_HITS: if (hit_valid_i) begin
        if (cnt_q != {CNT_W{1'b1}}) cnt_d = cnt_q + 1'b1;
        if (hit_last_i) st_d = C_READY;
      end
      C_READY: if (take_i) st_d = C_SEND;
      C_SEND:  if (end_i)  st_d = C_WAIT;
      default: st_d = C_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= C_WAIT;
      bx_q    <= '0;
      full_q  <= 1'b0;
      nohit_q <= 1'b0;
      thr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      st_q <= st_d;
      if (ld_en) begin
        bx_q    <= evt_bx_i;
        full_q  <= evt_full_i;
        nohit_q <= evt_nohit_i;
        thr_q   <= thr_i;
      end
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign wr_en_o   = hit_fire && (cnt_q < CNT_W'(MAXH));
  assign wr_addr_o = cnt_q[LEN_W-1:0];
  assign wr_data_o = hit_word_i;

  assign is_trunc     = full_q || (cnt_q > CNT_W'(thr_q));
  assign desc_valid_o = (st_q == C_READY);

  always_comb begin
    desc_o.bx = bx_q;
    if (nohit_q) begin
      desc_o.kind = K_EMPTY;
      desc_o.len  = '0;
    end else if (is_trunc) begin
      desc_o.kind = K_TRUNC;
      desc_o.len  = cnt_q[CNT_W-1:2];
    end else begin
      desc_o.kind = K_NORMAL;
      desc_o.len  = cnt_q[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/zsp_serial.sv
module zsp_serial
  import zsp_pkg::*;
#(
  parameter logic [WORD_W-1:0] SYNC_PAT = 12'hAF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_ready_i,
  output logic             ser_valid_o,
  output logic             ser_bit_o,
  input  logic             desc_valid_i,
  input  desc_t            desc_i,
  output logic             take_o,
  output logic             end_o,
  output logic [LEN_W-1:0] rd_addr_o,
  input  logic [HIT_W-1:0] rd_data_i,
  input  logic             sync_req_i,
  output logic             sync_ack_o
);
  localparam logic [HDR_W-1:0] IDLE_PAT = {{BX_W{1'b0}}, 2'b11};
  localparam logic [LEN_W-1:0] PAD      = '0;

  logic              act_q, act_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [BITS_W-1:0] bits_q, bits_d;
  logic [LEN_W-1:0]  hits_q, hits_d;
  logic [LEN_W-1:0]  rd_q, rd_d;
  logic              evt_q, evt_d;
  logic              ack_q, ack_d;
  logic              fire, word_end, boundary, next_hit;

  assign fire     = act_q && ser_ready_i;
  assign word_end = fire && (bits_q == BITS_W'(1));
  assign next_hit = word_end && (hits_q != '0);
  assign boundary = !act_q || (word_end && (hits_q == '0));
  assign end_o    = act_q && evt_q && word_end && (hits_q == '0);

  always_comb begin
    act_d  = act_q;
    sh_d   = sh_q;
    bits_d = bits_q;
    hits_d = hits_q;
    rd_d   = rd_q;
    evt_d  = evt_q;
    ack_d  = 1'b0;
    take_o = 1'b0;
    if (fire) begin
      sh_d   = sh_q << 1;
      bits_d = bits_q - BITS_W'(1);
    end
    if (next_hit) begin
      sh_d   = rd_data_i;
      bits_d = BITS_W'(HIT_W);
      hits_d = hits_q - 1'b1;
      rd_d   = rd_q + 1'b1;
    end else if (boundary) begin
      act_d  = 1'b1;
      rd_d   = '0;
      hits_d = '0;
      evt_d  = 1'b0;
      if (sync_req_i) begin
        sh_d   = SYNC_PAT;
        bits_d = BITS_W'(WORD_W);
        ack_d  = 1'b1;
      end else if (desc_valid_i) begin
        evt_d  = 1'b1;
        take_o = 1'b1;
        case (desc_i.kind)
          K_NORMAL: begin
            sh_d   = {desc_i.bx, 2'b00, desc_i.len};
            bits_d = BITS_W'(WORD_W);
            hits_d = desc_i.len;
          end
          K_TRUNC: begin
            sh_d   = {desc_i.bx, 2'b01, desc_i.len};
            bits_d = BITS_W'(WORD_W);
          end
          default: begin
            sh_d   = {desc_i.bx, 2'b10, PAD};
            bits_d = BITS_W'(HDR_W);
          end
        endcase
      end else begin
        sh_d   = {IDLE_PAT, PAD};
        bits_d = BITS_W'(HDR_W);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sh_q   <= '0;
      bits_q <= '0;
      hits_q <= '0;
      rd_q   <= '0;
      evt_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      sh_q   <= sh_d;
      bits_q <= bits_d;
      hits_q <= hits_d;
      rd_q   <= rd_d;
      evt_q  <= evt_d;
      ack_q  <= ack_d;
    end
  end

  assign ser_valid_o = act_q;
  assign ser_bit_o   = sh_q[WORD_W-1];
  assign rd_addr_o   = rd_q;
  assign sync_ack_o  = ack_q;
endmodule

// File: rtl/zsp_packet_enc.sv
module zsp_packet_enc
  import zsp_pkg::*;
#(
  parameter logic [WORD_W-1:0] SYNC_PAT = 12'hAF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] thr_i,
  input  logic             evt_valid_i,
  output logic             evt_ready_o,
  input  logic [BX_W-1:0]  evt_bx_i,
  input  logic             evt_nohit_i,
  input  logic             evt_full_i,
  input  logic             hit_valid_i,
  output logic             hit_ready_o,
  input  logic [CH_W-1:0]  hit_chan_i,
  input  logic [ADC_W-1:0] hit_adc_i,
  input  logic             hit_last_i,
  input  logic             sync_req_i,
  output logic             sync_ack_o,
  output logic             ser_valid_o,
  input  logic             ser_ready_i,
  output logic             ser_bit_o
);
  logic [1:0]       rst_sh_q;
  logic             rst_s;
  logic             wr_en;
  logic [LEN_W-1:0] wr_addr, rd_addr;
  logic [HIT_W-1:0] wr_data, rd_data;
  logic             desc_valid, pkt_take, pkt_end;
  desc_t            desc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_s = rst_sh_q[1];

  zsp_collect u_col (
    .clk          (clk),
    .rst_n        (rst_s),
    .thr_i        (thr_i),
    .evt_valid_i  (evt_valid_i),
    .evt_ready_o  (evt_ready_o),
    .evt_bx_i     (evt_bx_i),
    .evt_nohit_i  (evt_nohit_i),
    .evt_full_i   (evt_full_i),
    .hit_valid_i  (hit_valid_i),
    .hit_ready_o  (hit_ready_o),
    .hit_word_i   ({hit_chan_i, hit_adc_i}),
    .hit_last_i   (hit_last_i),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .desc_valid_o (desc_valid),
    .desc_o       (desc),
    .take_i       (pkt_take),
    .end_i        (pkt_end)
  );

  zsp_hitmem #(.DEPTH(DEPTH), .W(HIT_W)) u_mem (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  zsp_serial #(.SYNC_PAT(SYNC_PAT)) u_ser (
    .clk          (clk),
    .rst_n        (rst_s),
    .ser_ready_i  (ser_ready_i),
    .ser_valid_o  (ser_valid_o),
    .ser_bit_o    (ser_bit_o),
    .desc_valid_i (desc_valid),
    .desc_i       (desc),
    .take_o       (pkt_take),
    .end_o        (pkt_end),
    .rd_addr_o    (rd_addr),
    .rd_data_i    (rd_data),
    .sync_req_i   (sync_req_i),
    .sync_ack_o   (sync_ack_o)
  );
endmodule

// File: rtl/zsp_packet_enc_chk.sv
module zsp_packet_enc_chk #(
  parameter logic [11:0] SYNC_PAT = 12'hAF0
) (
  input logic clk,
  input logic rst_n,
  input logic evt_valid_i,
  input logic evt_ready_o,
  input logic hit_ready_o,
  input logic sync_req_i,
  input logic sync_ack_o,
  input logic ser_valid_o,
  input logic ser_ready_i,
  input logic ser_bit_o,
  input logic pkt_end
);
  logic [1:0] inflight_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight_q <= 2'd0;
    else if (evt_valid_i && evt_ready_o && !pkt_end) inflight_q <= inflight_q + 2'd1;
    else if (pkt_end && !(evt_valid_i && evt_ready_o)) inflight_q <= inflight_q - 2'd1;
  end

  a_r1_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_ready_o && evt_ready_o));

  a_r2_valid_stays: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid_o |=> ser_valid_o);

  a_r2_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid_o && !ser_ready_i) |=> $stable(ser_bit_o));

  a_r9_one_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= 2'd1);

  a_r9_ready_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ready_o |-> (inflight_q == 2'd0));

  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ack_o |=> !sync_ack_o);

  a_r10_ack_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ack_o |-> (ser_valid_o && ser_bit_o == SYNC_PAT[11]));

  a_r10_ack_requested: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ack_o) |-> $past(sync_req_i));
endmodule

bind zsp_packet_enc zsp_packet_enc_chk #(.SYNC_PAT(SYNC_PAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_s),
  .evt_valid_i (evt_valid_i),
  .evt_ready_o (evt_ready_o),
  .hit_ready_o (hit_ready_o),
  .sync_req_i  (sync_req_i),
  .sync_ack_o  (sync_ack_o),
  .ser_valid_o (ser_valid_o),
  .ser_ready_i (ser_ready_i),
  .ser_bit_o   (ser_bit_o),
  .pkt_end     (pkt_end)
);

// File: tb/sim_zsp_packet_enc.sv
`timescale 1ns/1ps
module sim_zsp_packet_enc;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] thr_i;
  logic       evt_valid_i, evt_nohit_i, evt_full_i;
  logic [3:0] evt_bx_i;
  logic       evt_ready_o;
  logic       hit_valid_i, hit_last_i, hit_ready_o;
  logic [6:0] hit_chan_i;
  logic [4:0] hit_adc_i;
  logic       sync_req_i, sync_ack_o;
  logic       ser_valid_o, ser_ready_i, ser_bit_o;

  int   checks = 0;
  int   errors = 0;
  bit   bq[$];
  bit   stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA7;
  logic [3:0] bxn = 4'd0;

  localparam int K_EMPTY = 0, K_NORMAL = 1, K_TRUNC = 2;

  always #2.5 clk = ~clk;

  zsp_packet_enc u0 (.*);

  always @(negedge clk)
    if (rst_n && ser_valid_o && ser_ready_i) bq.push_back(ser_bit_o);

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (stall_mode) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ser_ready_i = lfsr[0];
    end
  endtask

  function automatic logic [11:0] hit_of(logic [3:0] bx, int i);
    logic [6:0] ch;
    logic [4:0] ad;
    ch = 7'(int'(bx) * 9 + i * 5);
    ad = 5'(i * 3 + int'(bx) + 1);
    return {ch, ad};
  endfunction

  task automatic pop_bits(int n, output logic [31:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      while (bq.size() == 0) tick();
      v = {v[30:0], 1'(bq.pop_front())};
    end
  endtask

  task automatic next_hdr(output logic [31:0] h);
    do pop_bits(6, h); while (h == 32'b000011);
  endtask

  task automatic put_event(logic [3:0] bx, bit nohit, bit full, int n,
                           logic [5:0] thr_acc, logic [5:0] thr_mid);
    bit r;
    thr_i = thr_acc;
    evt_bx_i = bx; evt_nohit_i = nohit; evt_full_i = full; evt_valid_i = 1'b1;
    do begin r = evt_ready_o; tick(); end while (!r);
    evt_valid_i = 1'b0;
    thr_i = thr_mid;
    for (int i = 0; i < n; i++) begin
      {hit_chan_i, hit_adc_i} = hit_of(bx, i);
      hit_last_i = (i == n - 1);
      hit_valid_i = 1'b1;
      do begin r = hit_ready_o; tick(); end while (!r);
    end
    hit_valid_i = 1'b0;
    hit_last_i = 1'b0;
  endtask

  task automatic expect_pkt(string tag, logic [3:0] bx, int kind, int len, int n);
    logic [31:0] h, v;
    next_hdr(h);
    if (kind == K_EMPTY) begin
      chk({tag, " header"}, h, {26'd0, bx, 2'b10});
      return;
    end
    chk({tag, " header"}, h, {26'd0, bx, (kind == K_TRUNC) ? 2'b01 : 2'b00});
    pop_bits(6, v);
    chk({tag, " length"}, v, 32'(len));
    if (kind == K_NORMAL)
      for (int i = 0; i < n; i++) begin
        pop_bits(12, v);
        chk({tag, " hit word"}, v, {20'd0, hit_of(bx, i)});
      end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst_n = 1'b0; thr_i = 6'd63; evt_valid_i = 0; evt_nohit_i = 0; evt_full_i = 0;
    evt_bx_i = 0; hit_valid_i = 0; hit_chan_i = 0; hit_adc_i = 0; hit_last_i = 0;
    sync_req_i = 0; ser_ready_i = 1'b1;
    repeat (3) tick();
    chk("R1 valid in reset", ser_valid_o, 0);
    chk("R1 evt_ready in reset", evt_ready_o, 1);
    chk("R1 hit_ready in reset", hit_ready_o, 0);
    chk("R1 sync_ack in reset", sync_ack_o, 0);
    rst_n = 1'b1;
    pop_bits(6, v);
    chk("R1 R8 first packet idle", v, 32'b000011);
    chk("R2 valid after reset", ser_valid_o, 1);
  endtask

  task automatic t_empty();
    logic [31:0] v;
    put_event(bxn, 1'b1, 1'b0, 0, 6'd63, 6'd63);
    chk("R9 evt_ready low after accept", evt_ready_o, 0);
    expect_pkt("R3 empty", bxn, K_EMPTY, 0, 0);
    pop_bits(6, v);
    chk("R8 idle when nothing pending", v, 32'b000011);
    bxn++;
    put_event(bxn, 1'b1, 1'b1, 0, 6'd63, 6'd63);
    expect_pkt("R3 nohit beats full", bxn, K_EMPTY, 0, 0);
    bxn++;
  endtask

  task automatic t_normal();
    put_event(bxn, 1'b0, 1'b0, 5, 6'd63, 6'd63);
    expect_pkt("R4 normal 5 hits", bxn, K_NORMAL, 5, 5);
    bxn++;
    put_event(bxn, 1'b0, 1'b0, 1, 6'd63, 6'd63);
    expect_pkt("R4 normal 1 hit", bxn, K_NORMAL, 1, 1);
    bxn++;
    put_event(bxn, 1'b0, 1'b0, 63, 6'd63, 6'd63);
    expect_pkt("R5 63 hits at threshold 63", bxn, K_NORMAL, 63, 63);
    bxn++;
  endtask

  task automatic t_thr_edge();
    put_event(bxn, 1'b0, 1'b0, 10, 6'd10, 6'd10);
    expect_pkt("R5 count equal threshold", bxn, K_NORMAL, 10, 10);
    bxn++;
    put_event(bxn, 1'b0, 1'b0, 11, 6'd10, 6'd10);
    expect_pkt("R5 count above threshold", bxn, K_TRUNC, 2, 0);
    bxn++;
  endtask

  task automatic t_trunc();
    put_event(bxn, 1'b0, 1'b1, 3, 6'd63, 6'd63);
    expect_pkt("R6 buffer full", bxn, K_TRUNC, 0, 0);
    bxn++;
    put_event(bxn, 1'b0, 1'b0, 100, 6'd63, 6'd63);
    expect_pkt("R6 100 hits quarter count", bxn, K_TRUNC, 25, 0);
    bxn++;
    put_event(bxn, 1'b0, 1'b0, 300, 6'd63, 6'd63);
    expect_pkt("R6 saturated count", bxn, K_TRUNC, 63, 0);
    bxn++;
  endtask

  task automatic t_thr_sampled();
    put_event(bxn, 1'b0, 1'b0, 5, 6'd63, 6'd2);
    expect_pkt("R7 lowered mid-event", bxn, K_NORMAL, 5, 5);
    bxn++;
    put_event(bxn, 1'b0, 1'b0, 5, 6'd2, 6'd63);
    expect_pkt("R7 raised mid-event", bxn, K_TRUNC, 1, 0);
    bxn++;
    thr_i = 6'd63;
  endtask

  task automatic t_stall();
    logic b0;
    tick();
    ser_ready_i = 1'b0;
    tick();
    b0 = ser_bit_o;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R2 bit held while stalled", ser_bit_o, b0);
    end
    stall_mode = 1'b1;
    put_event(bxn, 1'b0, 1'b0, 7, 6'd63, 6'd63);
    expect_pkt("R2 normal under back-pressure", bxn, K_NORMAL, 7, 7);
    stall_mode = 1'b0;
    ser_ready_i = 1'b1;
    bxn++;
  endtask

  task automatic t_order();
    for (int k = 0; k < 17; k++) begin
      put_event(bxn, 1'b1, 1'b0, 0, 6'd63, 6'd63);
      expect_pkt("R9 sequential order", bxn, K_EMPTY, 0, 0);
      bxn++;
    end
  endtask

  task automatic t_sync();
    logic [31:0] v;
    int k;
    ser_ready_i = 1'b0;
    put_event(bxn, 1'b1, 1'b0, 0, 6'd63, 6'd63);
    sync_req_i = 1'b1;
    tick();
    ser_ready_i = 1'b1;
    k = 0;
    while (!sync_ack_o && k < 40) begin tick(); k++; end
    chk("R10 ack pulse seen", sync_ack_o, 1);
    chk("R10 first sync bit at ack", ser_bit_o, 1);
    sync_req_i = 1'b0;
    tick();
    chk("R10 ack lasts one cycle", sync_ack_o, 0);
    next_hdr(v);
    chk("R10 sync upper half", v, 32'b101011);
    pop_bits(6, v);
    chk("R10 sync lower half", v, 32'b110000);
    expect_pkt("R10 event after sync", bxn, K_EMPTY, 0, 0);
    bxn++;
  endtask

  initial begin
    t_reset();
    t_empty();
    t_normal();
    t_thr_edge();
    t_trunc();
    t_thr_sampled();
    t_stall();
    t_order();
    t_sync();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule